// File: doc/BRIEF.md
# Sixteen-Line Nested Priority Interrupt Controller

This block collects sixteen hardware interrupt request lines in two groups of eight: lines 0 to 7 form the primary group and lines 8 to 15 form the secondary group. Requests are detected on rising edges and held until they are serviced. Each line can be masked on its own. A fixed priority is applied, where a lower line number always wins. The block raises one interrupt output toward the processor.

When the processor acknowledges, the block returns an 8-bit vector number. It also returns the byte address of the matching 4-byte entry in a 256-entry vector table. It records which lines are in service, so a more urgent line can interrupt a running handler. Lines of the same or lower priority are held back until an end-of-interrupt command is written. The masks, the two vector bases and that command all use one small write port.

Top module: `prio_irq_cascade`

## Requirements
- R1: A request bit is latched on a rising edge of its input line only. A line held high after it has been acknowledged raises no new request.
- R2: Mask bit n set to 1 keeps pending line n from raising `int_o`. Clearing the bit lets the still-pending request through. All masks are 0 after reset.
- R3: When several unmasked lines are pending, the acknowledge serves the lowest-numbered line.
- R4: The vector is the group base plus the line index within that group. A written base has its low 3 bits forced to zero. The reset bases are 0x08 for the primary group and 0x70 for the secondary group, so line 1 gives vector 9 and line 12 gives vector 0x74.
- R5: `vec_addr_o` equals the vector times 4, a 10-bit byte address (vector 9 gives 0x24).
- R6: An acknowledge taken while `int_o` is high clears the served request bit and sets its in-service bit. The vector appears on `vec_o` in the cycle after `inta`.
- R7: `int_o` is high exactly when the best pending unmasked line has a lower number than every in-service line. This lets a more urgent line interrupt a running handler.
- R8: An end-of-interrupt write clears only the lowest-numbered in-service bit.
- R9: An acknowledge while `int_o` is low returns the primary base plus 7 and changes no in-service bit.
- R10: The write port decodes `wr_addr` as follows: 0 is the primary mask, 1 the primary base, 2 the secondary mask, 3 the secondary base, and 4 the end-of-interrupt command (data ignored). Mask bit i of the secondary mask controls line 8+i.
- R11: After reset, `int_o` is 0 and `vec_o` and `vec_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt request lines, line 0 most urgent |
| inta | input | 1 | One-cycle acknowledge from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number of the last acknowledge |
| vec_addr_o | output | 10 | Byte address of that vector's table entry |

## Verification
The bench builds the block with its default bases, 0x08 and 0x70. With these values the keyboard mapping (line 1 to vector 9, entry at 0x24) and the secondary-group vectors can be checked directly. Later it rewrites both bases with values whose low bits are set, which exercises the forced zeroing. Random stimulus then mixes sparse edges, acknowledges, end-of-interrupt writes and mask changes. This reaches deep nesting and spurious acknowledges far more often than directed tests would.

// File: rtl/prio_irq_cascade.sv
module prio_irq_cascade #(
  parameter logic [7:0] PRI_BASE_RST = 8'h08,
  parameter logic [7:0] SEC_BASE_RST = 8'h70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        inta,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        int_o,
  output logic [7:0]  vec_o,
  output logic [9:0]  vec_addr_o
);

  function automatic logic [4:0] first_set(input logic [15:0] v);
    first_set = 5'd16;
    for (int i = 15; i >= 0; i--)
      if (v[i]) first_set = 5'(i);
  endfunction

  logic [15:0] irq_prev, irr, isr, mask;
  logic [7:0]  pri_base, sec_base, vec_q;

  wire [4:0]  best    = first_set(irr & ~mask);
  wire [4:0]  top     = first_set(isr);
  wire        ack_ok  = inta && int_o;
  wire        eoi     = wr_en && (wr_addr == 3'd4);
  wire [15:0] ack_set = ack_ok ? (16'd1 << best[3:0]) : 16'd0;
  wire [15:0] eoi_clr = (eoi && !top[4]) ? (16'd1 << top[3:0]) : 16'd0;

  assign int_o      = !best[4] && (best < top);
  assign vec_o      = vec_q;
  assign vec_addr_o = {vec_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= '0;
      irr      <= '0;
      isr      <= '0;
      mask     <= '0;
      pri_base <= PRI_BASE_RST & 8'hF8;
      sec_base <= SEC_BASE_RST & 8'hF8;
      vec_q    <= '0;
    end else begin
      irq_prev <= irq_in;
      irr      <= (irr & ~ack_set) | (irq_in & ~irq_prev);
      isr      <= (isr & ~eoi_clr) | ack_set;
      if (inta)
        vec_q <= ack_ok ? ((best[3] ? sec_base : pri_base) | {5'd0, best[2:0]})
                        : (pri_base | 8'd7);
      if (wr_en)
        case (wr_addr)
          3'd0: mask[7:0]  <= wr_data;
          3'd1: pri_base   <= wr_data & 8'hF8;
          3'd2: mask[15:8] <= wr_data;
          3'd3: sec_base   <= wr_data & 8'hF8;
          default: ;
        endcase
    end
  end

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~mask) != 16'd0));

  // R6
  ack_sets_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

  // R8
  eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != 16'd0 && !(inta && int_o)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R9
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_o && !eoi) |=> ((vec_o == ($past(pri_base) | 8'd7)) && $stable(isr)));

endmodule

// File: tb/tb_prio_irq_cascade.sv
module tb_prio_irq_cascade;
  logic        clk = 0, rst_n = 0;
  logic [15:0] irq_in = 0;
  logic        inta = 0, wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic        int_o;
  logic [7:0]  vec_o;
  logic [9:0]  vec_addr_o;

  prio_irq_cascade dut (.*);

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  string tag = "R7";
  logic [15:0] m_irr = 0, m_isr = 0, m_mask = 0, m_prev = 0, m_irq = 0;
  logic [7:0]  m_pb = 8'h08, m_sb = 8'h70, m_vec = 0;
  logic        vec_due = 0;

  function automatic int lowest(input logic [15:0] v);
    lowest = 16;
    for (int i = 15; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  function automatic logic exp_int();
    int b = lowest(m_irr & ~m_mask);
    return (b < 16) && (b < lowest(m_isr));
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] irq, input logic ack, input logic we,
                      input logic [2:0] a, input logic [7:0] d);
    int b, t;
    @(negedge clk);
    check(int_o == exp_int(), tag, int_o, exp_int());
    if (vec_due) begin
      check(vec_o == m_vec, "R4/R6 vector", vec_o, m_vec);
      check(vec_addr_o == {m_vec, 2'b00}, "R5 address", vec_addr_o, {m_vec, 2'b00});
    end
    irq_in = irq; inta = ack; wr_en = we; wr_addr = a; wr_data = d;
    b = lowest(m_irr & ~m_mask);
    t = lowest(m_isr);
    vec_due = ack;
    if (ack) begin
      if (exp_int()) begin
        m_vec = (b >= 8 ? m_sb : m_pb) | 8'(b % 8);
        m_irr[b] = 0;
        m_isr[b] = 1;
        if (we && a == 4 && t < 16) m_isr[t] = 0;
      end else begin
        m_vec = m_pb | 8'd7;
        if (we && a == 4 && t < 16) m_isr[t] = 0;
      end
    end else if (we && a == 4 && t < 16) m_isr[t] = 0;
    if (we)
      case (a)
        3'd0: m_mask[7:0]  = d;
        3'd1: m_pb         = d & 8'hF8;
        3'd2: m_mask[15:8] = d;
        3'd3: m_sb         = d & 8'hF8;
        default: ;
      endcase
    m_irr = m_irr | (irq & ~m_prev);
    m_prev = irq;
    m_irq = irq;
  endtask

  task automatic idle(); step(m_irq, 0, 0, 0, 0); endtask
  task automatic ack(); step(m_irq, 1, 0, 0, 0); endtask
  task automatic eoi(); step(m_irq, 0, 1, 4, 8'hA5); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(int_o == 0, "R11 int", int_o, 0);
    check(vec_o == 0, "R11 vec", vec_o, 0);
    check(vec_addr_o == 0, "R11 addr", vec_addr_o, 0);
    rst_n = 1;

    // R1: edge latch, held level does not re-request
    tag = "R1";
    step(16'h0008, 0, 0, 0, 0); idle(); ack(); eoi(); idle(); idle();
    step(16'h0000, 0, 0, 0, 0); idle();

    // R4 R5: keyboard line 1 -> vector 9 at 0x24; secondary line 12 -> 0x74
    tag = "R4";
    step(16'h0002, 0, 0, 0, 0); idle(); ack(); eoi();
    step(16'h1000, 0, 0, 0, 0); idle(); ack(); eoi(); idle();

    // R3: simultaneous lines 5, 9, 2 -> line 2 first
    tag = "R3";
    step(16'h0224, 0, 0, 0, 0); ack(); ack(); idle();

    // R7: line 9 and 5 blocked behind in-service 2; nesting with line 0
    tag = "R7";
    step(16'h0001, 0, 0, 0, 0); idle(); ack(); eoi(); eoi(); ack(); ack(); eoi(); eoi(); idle();

    // R2 R10: mask line 4 via primary mask, line 10 via secondary mask
    tag = "R2";
    step(16'h0000, 0, 1, 0, 8'h10); step(16'h0010, 0, 1, 2, 8'h04);
    step(16'h0410, 0, 0, 0, 0); idle();
    step(16'h0410, 0, 1, 0, 8'h00); idle(); ack(); eoi();
    step(16'h0410, 0, 1, 2, 8'h00); idle(); ack(); eoi(); idle();

    // R9: spurious acknowledge
    tag = "R9";
    step(16'h0000, 1, 0, 0, 0); idle();

    // R4 R10: base writes with low bits set
    tag = "R4";
    step(16'h0000, 0, 1, 1, 8'h27); step(16'h0000, 0, 1, 3, 8'hFF);
    step(16'h0080, 0, 0, 0, 0); ack(); eoi();
    step(16'h8080, 0, 0, 0, 0); ack(); eoi(); step(16'h0000, 1, 0, 0, 0); idle();

    // R6 R8 R7: random mix
    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] irq = m_irq;
      int r = $urandom % 100;
      if ($urandom % 4 == 0) irq[$urandom % 16] = ~irq[$urandom % 16];
      if (r < 20)      step(irq, 1, 0, 0, 0);
      else if (r < 35) step(irq, 0, 1, 4, 0);
      else if (r < 38) step(irq, 1, 1, 4, 0);
      else if (r < 41) step(irq, 0, 1, 3'(($urandom % 2) * 2), 8'($urandom) & 8'h5A);
      else if (r < 43) step(irq, 0, 1, 3'(1 + ($urandom % 2) * 2), 8'($urandom));
      else             step(irq, 0, 0, 0, 0);
    end
    idle();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule